// File: doc/BRIEF.md
# Logic-Immediate Instruction Execute Unit

This block carries out a small part of a 32-bit load/store instruction set. It accepts one instruction word per clock, qualified by a valid strobe. The supported forms are OR, AND and XOR of a register with a 16-bit constant, and an unsigned register-register add. The unit decodes the word and reads its operands from a local 32 x 32-bit register file. It widens the constant with zeros to full width, forms the result and writes it back into the register file on the next rising clock edge.

The top six bits select the instruction layout. In the constant forms, the source register, the destination register and the constant follow the opcode in that order. The add form names two sources and a destination, and a low six-bit function code selects the add. Register 0 is hardwired to zero. Any word the unit does not recognise changes nothing and raises a one-cycle illegal flag.

A registered debug read port lets the surrounding logic or a testbench observe any register.

Top module: `lix_exec_top`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and clears `illegal_o`.
- R2: Opcode bits [31:26] = 6'b001101 (OR-immediate) writes register [20:16] with register [25:21] OR'd with bits [15:0] zero-extended to 32 bits; word 0x34080002 leaves register 8 holding 0x00000002.
- R3: Opcode 6'b001100 (AND-immediate) uses the same field positions as R2 and writes register [25:21] AND'd with the zero-extended constant, so the upper 16 result bits are always zero.
- R4: Opcode 6'b001110 (XOR-immediate) uses the same field positions as R2 and writes register [25:21] XOR'd with the zero-extended constant; with register 15 = 0x00000FA5 and constant 0x368F, OR, AND and XOR give 0x00003FAF, 0x00000685 and 0x0000392A.
- R5: Opcode 6'b000000 with function bits [5:0] = 6'b100001 writes register [15:11] with the sum of registers [25:21] and [20:16] modulo 2^32, regardless of bits [10:6]; word 0x01095021 adds registers 8 and 9 into register 10.
- R6: Register 0 always reads as zero, both as an operand and on the debug port, and an instruction that names it as destination leaves it zero.
- R7: Any other opcode, or opcode 6'b000000 with any other function value, performs no write and drives `illegal_o` high in the cycle after the instruction; `illegal_o` is low after each legal or absent instruction.
- R8: The write takes effect on the clock edge that accepts the instruction, so an instruction on the next cycle that reads the same register uses the new value.
- R9: `dbg_data_o` shows the register selected by `dbg_addr_i` one clock after the address is presented.
- R10: While `instr_valid_i` is low, the instruction word has no effect on any register or on `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 32 | Instruction word |
| dbg_addr_i | input | 5 | Register index for the debug read |
| dbg_data_o | output | 32 | Registered contents of the selected register |
| illegal_o | output | 1 | One-cycle pulse after an unrecognised instruction |

## Verification
A register that is corrupted, or a write that lands on the wrong index, shows nothing on the ports until a debug read of that register is made. It also shows as a wrong value one cycle after a later instruction uses it as a source. For this reason the bench reads back the whole register file periodically during the random runs and compares it with its own model. A decode error shows at once: `illegal_o` takes the wrong value one cycle after the instruction. Any forwarding or timing error shows on the very next back-to-back instruction.

// File: rtl/lix_pkg.sv
package lix_pkg;

  localparam int unsigned OPC_W = 6;
  localparam int unsigned FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REGREG = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ORIMM  = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_ANDIMM = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_XORIMM = 6'b001110;
  localparam logic [FN_W-1:0]  FN_ADDU    = 6'b100001;

  typedef enum logic [1:0] {
    ALU_OR  = 2'd0,
    ALU_AND = 2'd1,
    ALU_XOR = 2'd2,
    ALU_ADD = 2'd3
  } alu_op_e;

endpackage

// File: rtl/lix_decode.sv
module lix_decode
  import lix_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned IMM_W   = 16
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               legal,
  output alu_op_e            op,
  output logic               use_imm,
  output logic [REG_AW-1:0]  src_a,
  output logic [REG_AW-1:0]  src_b,
  output logic [REG_AW-1:0]  dst,
  output logic [IMM_W-1:0]   imm
);

  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned RS_LSB  = OPC_LSB - REG_AW;
  localparam int unsigned RT_LSB  = RS_LSB - REG_AW;
  localparam int unsigned RD_LSB  = RT_LSB - REG_AW;

  logic [OPC_W-1:0]  opc;
  logic [FN_W-1:0]   fn;
  logic [REG_AW-1:0] rd_field;

  assign opc      = instr[OPC_LSB +: OPC_W];
  assign fn       = instr[FN_W-1:0];
  assign rd_field = instr[RD_LSB +: REG_AW];
  assign src_a    = instr[RS_LSB +: REG_AW];
  assign src_b    = instr[RT_LSB +: REG_AW];
  assign imm      = instr[IMM_W-1:0];

  always_comb begin
    legal   = 1'b0;
    op      = ALU_OR;
    use_imm = 1'b1;
    dst     = instr[RT_LSB +: REG_AW];
    case (opc)
      OPC_ORIMM: begin
        legal = 1'b1;
        op    = ALU_OR;
      end
      OPC_ANDIMM: begin
        legal = 1'b1;
        op    = ALU_AND;
      end
      OPC_XORIMM: begin
        legal = 1'b1;
        op    = ALU_XOR;
      end
      OPC_REGREG: begin
        use_imm = 1'b0;
        dst     = rd_field;
        if (fn == FN_ADDU) begin
          legal = 1'b1;
          op    = ALU_ADD;
        end
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lix_alu.sv
module lix_alu
  import lix_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  alu_op_e           op,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b_reg,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_wide;
  logic [DATA_W-1:0] b;

  assign imm_wide = {{PAD_W{1'b0}}, imm};
  assign b        = use_imm ? imm_wide : b_reg;

  always_comb begin
    case (op)
      ALU_OR:  result = a | b;
      ALU_AND: result = a & b;
      ALU_XOR: result = a ^ b;
      ALU_ADD: result = a + b;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/lix_regfile.sv
module lix_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);

  localparam int unsigned NREGS = 1 << REG_AW;

  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) begin
        mem[i] <= '0;
      end
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_data <= '0;
    end else begin
      dbg_data <= mem[dbg_addr];
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  AST_R0_OPERAND_ZERO: assert property (@(posedge clk) disable iff (rst)
    (raddr_a == '0) |-> (rdata_a == '0)); // R6

endmodule

// File: rtl/lix_exec_top.sv
module lix_exec_top
  import lix_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned IMM_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [REG_AW-1:0]  dbg_addr_i,
  output logic [DATA_W-1:0]  dbg_data_o,
  output logic               illegal_o
);

  logic              legal;
  alu_op_e           op;
  logic              use_imm;
  logic [REG_AW-1:0] src_a;
  logic [REG_AW-1:0] src_b;
  logic [REG_AW-1:0] dst;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;
  logic              wr_en;
  logic              started;

  lix_decode #(
    .INSTR_W(INSTR_W),
    .REG_AW (REG_AW),
    .IMM_W  (IMM_W)
  ) u_decode (
    .instr  (instr_i),
    .legal  (legal),
    .op     (op),
    .use_imm(use_imm),
    .src_a  (src_a),
    .src_b  (src_b),
    .dst    (dst),
    .imm    (imm)
  );

  lix_regfile #(
    .DATA_W(DATA_W),
    .REG_AW(REG_AW)
  ) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .raddr_a (src_a),
    .rdata_a (opnd_a),
    .raddr_b (src_b),
    .rdata_b (opnd_b),
    .we      (wr_en),
    .waddr   (dst),
    .wdata   (alu_res),
    .dbg_addr(dbg_addr_i),
    .dbg_data(dbg_data_o)
  );

  lix_alu #(
    .DATA_W(DATA_W),
    .IMM_W (IMM_W)
  ) u_alu (
    .op     (op),
    .use_imm(use_imm),
    .a      (opnd_a),
    .b_reg  (opnd_b),
    .imm    (imm),
    .result (alu_res)
  );

  assign wr_en = instr_valid_i && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_o <= 1'b0;
      started   <= 1'b0;
    end else begin
      illegal_o <= instr_valid_i && !legal;
      started   <= 1'b1;
    end
  end

  AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> $past(instr_valid_i)); // R7

  AST_AND_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == ALU_AND) |-> (alu_res[DATA_W-1:IMM_W] == '0)); // R3

  AST_OR_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == ALU_OR) |-> (alu_res[DATA_W-1:IMM_W] == opnd_a[DATA_W-1:IMM_W])); // R2

  AST_DBG_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (started && $past(dbg_addr_i) == '0 && !$past(rst)) |-> (dbg_data_o == '0)); // R6

endmodule

// File: tb/tb_lix_exec_top.sv
`timescale 1ns/1ps
module tb_lix_exec_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [4:0]  dbg_addr_i = '0;
  logic [31:0] dbg_data_o;
  logic        illegal_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] ref_rf [32];

  always #10 clk = ~clk;

  lix_exec_top dut (
    .clk          (clk),
    .rst          (rst),
    .instr_valid_i(instr_valid_i),
    .instr_i      (instr_i),
    .dbg_addr_i   (dbg_addr_i),
    .dbg_data_o   (dbg_data_o),
    .illegal_o    (illegal_o)
  );

  function automatic logic [31:0] mk_imm(logic [5:0] opc, logic [4:0] rs, logic [4:0] rt,
                                         logic [15:0] k);
    return {opc, rs, rt, k};
  endfunction

  function automatic logic [31:0] mk_add(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                         logic [4:0] sh);
    return {6'b000000, rs, rt, rd, sh, 6'b100001};
  endfunction

  // Reference model: applies one instruction, returns expected illegal flag
  function automatic bit model(logic [31:0] w);
    logic [31:0] a, b, k, r;
    logic [4:0]  d;
    bit ok;
    a  = ref_rf[w[25:21]];
    b  = ref_rf[w[20:16]];
    k  = {16'h0000, w[15:0]};
    d  = w[20:16];
    ok = 1;
    r  = '0;
    case (w[31:26])
      6'b001101: r = a | k;
      6'b001100: r = a & k;
      6'b001110: r = a ^ k;
      6'b000000: begin
        d = w[15:11];
        if (w[5:0] == 6'b100001) r = a + b;
        else ok = 0;
      end
      default: ok = 0;
    endcase
    if (ok && d != 5'd0) ref_rf[d] = r;
    return !ok;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exec(logic [31:0] w);
    bit exp_ill;
    instr_valid_i = 1'b1;
    instr_i = w;
    @(posedge clk);
    #2;
    instr_valid_i = 1'b0;
    exp_ill = model(w);
    chk("R7 illegal flag", {31'b0, illegal_o}, {31'b0, exp_ill});
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    dbg_addr_i = a;
    @(posedge clk);
    #2;
    v = dbg_data_o;
  endtask

  task automatic check_reg(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 32; i++) check_reg(req, i[4:0], ref_rf[i]);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] v;
    void'($urandom(32'h1dea5eed));
    for (int i = 0; i < 32; i++) ref_rf[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    chk("R1 illegal after reset", {31'b0, illegal_o}, 32'h0);
    check_all("R1 reset clears");

    // R2: canonical load word
    exec(32'h34080002);
    check_reg("R2 or-imm load", 5'd8, 32'h00000002);

    // R2 R3 R4: three ops on the same pattern
    exec(mk_imm(6'b001101, 5'd0, 5'd15, 16'h0FA5));
    exec(mk_imm(6'b001101, 5'd15, 5'd8, 16'h368F));
    exec(mk_imm(6'b001100, 5'd15, 5'd9, 16'h368F));
    exec(mk_imm(6'b001110, 5'd15, 5'd10, 16'h368F));
    check_reg("R2 or result", 5'd8, 32'h00003FAF);
    check_reg("R3 and result", 5'd9, 32'h00000685);
    check_reg("R4 xor result", 5'd10, 32'h0000392A);

    // R5: canonical add word
    exec(32'h01095021);
    check_reg("R5 add result", 5'd10, 32'h00004634);

    // R6: write to register 0 ignored, reads as zero
    exec(mk_imm(6'b001101, 5'd15, 5'd0, 16'hFFFF));
    check_reg("R6 r0 stays zero", 5'd0, 32'h0);
    exec(mk_add(5'd0, 5'd15, 5'd11, 5'd0));
    check_reg("R6 r0 operand", 5'd11, 32'h00000FA5);

    // R8: back-to-back dependency
    exec(mk_imm(6'b001101, 5'd0, 5'd1, 16'h1234));
    exec(mk_imm(6'b001110, 5'd1, 5'd2, 16'hFFFF));
    exec(mk_add(5'd2, 5'd1, 5'd3, 5'd7));
    check_reg("R8 forward xor", 5'd2, 32'h0000EDCB);
    check_reg("R8 forward add", 5'd3, 32'h0000FFFF);

    // R5: wrap modulo 2^32, shift field ignored
    exec(mk_imm(6'b001101, 5'd0, 5'd4, 16'hFFFF));
    exec(mk_imm(6'b001101, 5'd0, 5'd5, 16'hFFFF));
    for (int i = 0; i < 16; i++) exec(mk_add(5'd5, 5'd5, 5'd5, 5'd31));
    check_reg("R5 shift up", 5'd5, 32'hFFFF0000);
    exec(mk_add(5'd5, 5'd4, 5'd6, 5'd0));
    check_reg("R5 all ones", 5'd6, 32'hFFFFFFFF);
    exec(mk_imm(6'b001101, 5'd0, 5'd7, 16'h0001));
    exec(mk_add(5'd6, 5'd7, 5'd6, 5'd0));
    check_reg("R5 wrap to zero", 5'd6, 32'h00000000);

    // R7: bad opcode, bad function; then pulse drops
    exec(mk_imm(6'b100011, 5'd15, 5'd12, 16'hAAAA));
    check_reg("R7 no write bad opcode", 5'd12, 32'h0);
    exec({6'b000000, 5'd15, 5'd15, 5'd13, 5'd0, 6'b100000});
    exec(mk_imm(6'b001101, 5'd0, 5'd14, 16'h0001));
    check_reg("R7 no write bad function", 5'd13, 32'h0);

    // R10: valid low has no effect
    instr_i = mk_imm(6'b001101, 5'd0, 5'd9, 16'h5555);
    instr_valid_i = 1'b0;
    @(posedge clk);
    #2;
    chk("R10 no illegal when idle", {31'b0, illegal_o}, 32'h0);
    instr_i = 32'hFC00_0000;
    @(posedge clk);
    #2;
    chk("R10 no illegal idle bad word", {31'b0, illegal_o}, 32'h0);
    check_reg("R10 reg untouched", 5'd9, 32'h00000685);

    // R9: debug port latency one cycle, address changes each cycle
    dbg_addr_i = 5'd8;
    @(posedge clk);
    #2;
    dbg_addr_i = 5'd9;
    chk("R9 dbg r8", dbg_data_o, 32'h00003FAF);
    @(posedge clk);
    #2;
    chk("R9 dbg r9", dbg_data_o, 32'h00000685);

    // Random mix with periodic full readback
    for (int n = 0; n < 1200; n++) begin
      int kind;
      kind = $urandom % 8;
      case (kind)
        0, 1: w = mk_imm(6'b001101, 5'($urandom), 5'($urandom), 16'($urandom));
        2:    w = mk_imm(6'b001100, 5'($urandom), 5'($urandom), 16'($urandom));
        3:    w = mk_imm(6'b001110, 5'($urandom), 5'($urandom), 16'($urandom));
        4, 5: w = mk_add(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
        6:    w = $urandom;
        default: begin
          w = {6'b000000, 20'($urandom), 6'($urandom)};
          if (w[5:0] == 6'b100001) w[5:0] = 6'b100101;
        end
      endcase
      exec(w);
      if (n % 100 == 99) check_all("R2 R3 R4 R5 R6 random readback");
    end
    rd(5'd0, v);
    chk("R6 final r0", v, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule